// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Bridge

This block connects an internal 8-bit data-memory request port to an external asynchronous SRAM over a narrow bus. The low address byte and the data byte share one 8-bit bidirectional bus. A separate 8-bit bus carries the high address byte. At the start of each access, an address-latch pulse tells an external transparent latch to capture the low address byte. After that, an active-low read or write strobe moves the data.

The 64 KiB external space is split into a lower sector and an upper sector. A 4-bit threshold compared against address bits 15:12 sets the boundary. Each sector has its own 2-bit wait setting, so a slow device and a fast device can share the bus. A bus keeper can be switched on to hold the shared bus at its last driven value while the bridge is not driving it.

The internal side issues single requests. A request is taken only while the bridge is idle. Completion is signalled by a one-cycle done pulse. For reads, the data arrives with that pulse.

The controller runs through the states IDLE, LATCH, ADDR_HOLD, STROBE, TAIL and FINISH:

- IDLE → LATCH when a request is present.
- LATCH → ADDR_HOLD always.
- ADDR_HOLD → STROBE always.
- STROBE stays in STROBE while wait cycles remain.
- STROBE → TAIL when the wait setting is 3.
- STROBE → FINISH otherwise.
- TAIL → FINISH always.
- FINISH → IDLE always.

Top module: `xmem_bridge`

## Requirements
- R1: After reset the outputs rest as follows: `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: The cycle after a request is accepted is the LATCH cycle.
  - During LATCH, `ale` is 1 for exactly one cycle.
  - `ad_o` carries address bits 7:0 with `ad_oe` = 1.
  - `addr_hi` carries address bits 15:8 for the whole access.
- R3: In the cycle after `ale` falls, `ad_o` still drives the same low address byte with `ad_oe` = 1.
- R4: A read holds `rd_n` low for 1, 2, 3 or 3 cycles for wait settings 0, 1, 2 and 3.
  - `ad_oe` is 0 while `rd_n` is low.
  - The bus value sampled in the last low cycle appears on `rd_data` together with `done`.
- R5: A write holds `wr_n` low for the same number of cycles as R4. During that whole time, `ad_o` drives the write data with `ad_oe` = 1.
- R6: With wait setting 3, there is one extra cycle between the strobe rising and `done`. During that cycle both strobes are high and `addr_hi` is unchanged. For settings 0, 1 and 2, `done` follows the strobe directly.
- R7: The wait setting is picked from the request address.
  - If address bits 15:12 are below `cfg_limit`, the access uses `cfg_ws_lo`.
  - Otherwise it uses `cfg_ws_hi`.
  - A limit of 0 sends every address to the upper sector.
- R8: `done` is a single-cycle pulse, one per accepted request. `rd_n` and `wr_n` are never low at the same time.
- R9: `req_valid` asserted while an access is in progress is ignored. It produces no additional access and no `done`.
- R10: While `ad_oe` is 0, `ad_o` holds the last value the bridge drove. `ad_keep` equals `cfg_keep_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read data, valid with `done` |
| cfg_ws_lo | input | 2 | Wait setting, lower sector |
| cfg_ws_hi | input | 2 | Wait setting, upper sector |
| cfg_limit | input | 4 | Sector threshold on address bits 15:12 |
| cfg_keep_en | input | 1 | Bus keeper enable |
| ale | output | 1 | Address latch enable (active high) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | Address bits 15:8 |
| ad_o | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus actively driven |
| ad_keep | output | 1 | Keeper holding the shared bus |
| ad_i | input | 8 | Shared bus input value |

## Verification
The hardest situations to reach from the ports are these:

- The TAIL cycle of wait setting 3 appearing in one sector while the other sector runs with no wait at all. The stimulus sets opposite wait values for the two sectors and moves the threshold to 0, to 8 and to 15, so that the same address switches between sectors.
- A request arriving mid-access. The stimulus raises `req_valid` during ADDR_HOLD and STROBE, and the scoreboard flags any `done` with no expected entry.
- The keeper. It is observed in idle periods after a write, where the data byte is retained, and after a read, where the low address byte is retained, with the enable both on and off.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_AHOLD,
        ST_STROBE,
        ST_TAIL,
        ST_FINISH
    } xmem_state_t;

    typedef enum logic [1:0] {
        DRV_NONE,
        DRV_ADDR,
        DRV_DATA
    } xmem_drv_t;

    localparam int WAIT_MAX = 2;
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);

    function automatic logic [WCNT_W-1:0] extra_cycles(input logic [1:0] ws);
        logic [WCNT_W-1:0] n;
        unique case (ws)
            2'd0:    n = WCNT_W'(0);
            2'd1:    n = WCNT_W'(1);
            default: n = WCNT_W'(WAIT_MAX);
        endcase
        return n;
    endfunction

    function automatic logic wants_tail(input logic [1:0] ws);
        return ws == 2'd3;
    endfunction

endpackage

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel #(
    parameter int AW        = 16,
    parameter int SECT_BITS = 4,
    parameter int WS_W      = 2
) (
    input  logic [AW-1:0]        addr,
    input  logic [SECT_BITS-1:0] limit,
    input  logic [WS_W-1:0]      ws_lo,
    input  logic [WS_W-1:0]      ws_hi,
    output logic [WS_W-1:0]      ws_sel
);
    localparam int TOP = AW - 1;

    logic [SECT_BITS-1:0] region;

    always_comb begin
        region = addr[TOP -: SECT_BITS];
        ws_sel = (region < limit) ? ws_lo : ws_hi;
    end
endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       we_q,
    input  logic [1:0] ws_q,
    output logic       accept,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output xmem_drv_t  drv_sel,
    output logic       sample_rd,
    output logic       done
);
    xmem_state_t       state, state_nx;
    logic [WCNT_W-1:0] wcnt, wcnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            wcnt  <= wcnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        wcnt_nx  = wcnt;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_LATCH;
            ST_LATCH:  state_nx = ST_AHOLD;
            ST_AHOLD: begin
                state_nx = ST_STROBE;
                wcnt_nx  = extra_cycles(ws_q);
            end
            ST_STROBE: begin
                if (wcnt != '0) begin
                    wcnt_nx = wcnt - WCNT_W'(1);
                end else if (wants_tail(ws_q)) begin
                    state_nx = ST_TAIL;
                end else begin
                    state_nx = ST_FINISH;
                end
            end
            ST_TAIL:   state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        ale       = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        drv_sel   = DRV_NONE;
        sample_rd = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   accept = req_valid;
            ST_LATCH: begin
                ale     = 1'b1;
                drv_sel = DRV_ADDR;
            end
            ST_AHOLD:  drv_sel = DRV_ADDR;
            ST_STROBE: begin
                if (we_q) begin
                    wr_n    = 1'b0;
                    drv_sel = DRV_DATA;
                end else begin
                    rd_n      = 1'b0;
                    sample_rd = (wcnt == '0);
                end
            end
            ST_TAIL:   ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/xmem_keeper.sv
module xmem_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_oe,
    input  logic [DW-1:0] drv_val,
    input  logic          keep_en,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe,
    output logic          bus_keep
);
    logic [DW-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held <= '0;
        else if (drv_oe) held <= drv_val;
    end

    always_comb begin
        bus_oe   = drv_oe;
        bus_o    = drv_oe ? drv_val : held;
        bus_keep = !drv_oe && keep_en;
    end
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int SECT_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    output logic                 done,
    output logic [DW-1:0]        rd_data,
    input  logic [1:0]           cfg_ws_lo,
    input  logic [1:0]           cfg_ws_hi,
    input  logic [SECT_BITS-1:0] cfg_limit,
    input  logic                 cfg_keep_en,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [AW-DW-1:0]     addr_hi,
    output logic [DW-1:0]        ad_o,
    output logic                 ad_oe,
    output logic                 ad_keep,
    input  logic [DW-1:0]        ad_i
);
    localparam int HI_W = AW - DW;

    logic            accept, sample_rd;
    xmem_drv_t       drv_sel;
    logic [1:0]      ws_pick, ws_q;
    logic            we_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wd_q, rd_q, drv_val;
    logic            drv_oe;

    xmem_sector_sel #(.AW(AW), .SECT_BITS(SECT_BITS), .WS_W(2)) u_sect (
        .addr   (req_addr),
        .limit  (cfg_limit),
        .ws_lo  (cfg_ws_lo),
        .ws_hi  (cfg_ws_hi),
        .ws_sel (ws_pick)
    );

    xmem_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .we_q      (we_q),
        .ws_q      (ws_q),
        .accept    (accept),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .drv_sel   (drv_sel),
        .sample_rd (sample_rd),
        .done      (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
            wd_q   <= '0;
            ws_q   <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            we_q   <= req_we;
            wd_q   <= req_wdata;
            ws_q   <= ws_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_q <= '0;
        else if (sample_rd) rd_q <= ad_i;
    end

    always_comb begin
        drv_oe  = drv_sel != DRV_NONE;
        drv_val = (drv_sel == DRV_DATA) ? wd_q : addr_q[DW-1:0];
    end

    xmem_keeper #(.DW(DW)) u_keep (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_oe   (drv_oe),
        .drv_val  (drv_val),
        .keep_en  (cfg_keep_en),
        .bus_o    (ad_o),
        .bus_oe   (ad_oe),
        .bus_keep (ad_keep)
    );

    assign addr_hi = addr_q[AW-1 -: HI_W];
    assign rd_data = rd_q;
endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] addr_hi,
    input logic [7:0] ad_o,
    input logic       ad_oe,
    input logic       ad_keep,
    input logic       cfg_keep_en
);
    assert_ale_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe && rd_n && wr_n);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ad_oe && ad_o == $past(ad_o));

    assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ad_oe && $stable(ad_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_n == 1'b0 && wr_n == 1'b0));

    assert_done_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_n && wr_n && !ale && $stable(addr_hi));

    assert_keeper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ad_oe && $past(!ad_oe)) |-> $stable(ad_o));

    assert_keeper_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ad_keep |-> !ad_oe && cfg_keep_en);
endmodule

bind xmem_bridge xmem_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr_hi     (addr_hi),
    .ad_o        (ad_o),
    .ad_oe       (ad_oe),
    .ad_keep     (ad_keep),
    .cfg_keep_en (cfg_keep_en)
);

// File: tb/xmem_bridge_tb.sv
module xmem_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rd_data;
    logic [1:0]  cfg_ws_lo = '0, cfg_ws_hi = '0;
    logic [3:0]  cfg_limit = '0;
    logic        cfg_keep_en = 1'b0;
    logic        ale, rd_n, wr_n, ad_oe, ad_keep;
    logic [7:0]  addr_hi, ad_o;
    logic [7:0]  ad_i = '0;

    always #5 clk = ~clk;

    xmem_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi), .cfg_limit(cfg_limit),
        .cfg_keep_en(cfg_keep_en), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi(addr_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ad_keep(ad_keep), .ad_i(ad_i)
    );

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        int          strobe_len;
        int          tail_len;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] exp_mem[int];
    logic [7:0] sram[int];
    int total = 0, bad = 0;
    int outstanding = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // external SRAM with transparent address latch
    logic [7:0] sram_lat = '0;
    always @(negedge clk) begin
        if (ale) sram_lat = ad_o;
        if (!wr_n) sram[{addr_hi, sram_lat}] = ad_o;
        if (!rd_n) ad_i = sram.exists({addr_hi, sram_lat}) ? sram[{addr_hi, sram_lat}] : 8'h00;
    end

    // monitor / scoreboard
    logic [7:0] mon_lat = '0;
    logic       prev_ale = 1'b0;
    int strb = 0, tail = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                mon_lat = ad_o;
                if (exp_q.size() > 0) begin
                    chk(ad_oe && ad_o == exp_q[0].addr[7:0], "R2 low addr", ad_o, exp_q[0].addr[7:0]);
                    chk(addr_hi == exp_q[0].addr[15:8], "R2 high addr", addr_hi, exp_q[0].addr[15:8]);
                end
            end
            if (prev_ale && !ale)
                chk(ad_oe && ad_o == mon_lat && !ale, "R3 addr hold", ad_o, mon_lat);
            if (!rd_n) begin
                strb++;
                chk(!ad_oe, "R4 bus released", ad_oe, 0);
            end
            if (!wr_n) begin
                strb++;
                if (exp_q.size() > 0)
                    chk(ad_oe && ad_o == exp_q[0].data, "R5 write data", ad_o, exp_q[0].data);
            end
            if (rd_n && wr_n && strb > 0 && !done) tail++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(strb == it.strobe_len, it.we ? "R5/R7 strobe len" : "R4/R7 strobe len",
                        strb, it.strobe_len);
                    chk(tail == it.tail_len, "R6 tail cycles", tail, it.tail_len);
                    if (!it.we) chk(rd_data == it.data, "R4 read data", rd_data, it.data);
                    outstanding--;
                end
                strb = 0;
                tail = 0;
            end
            prev_ale = ale;
        end
    end

    task automatic access(input logic we, input logic [15:0] addr, input logic [7:0] wd);
        item_t it;
        logic [1:0] ws;
        wait (outstanding == 0);
        @(negedge clk);
        ws = (addr[15:12] < cfg_limit) ? cfg_ws_lo : cfg_ws_hi;
        it.we = we;
        it.addr = addr;
        it.strobe_len = (ws == 2'd0) ? 1 : (ws == 2'd1) ? 2 : 3;
        it.tail_len = (ws == 2'd3) ? 1 : 0;
        if (we) begin
            it.data = wd;
            exp_mem[addr] = wd;
        end else begin
            it.data = exp_mem.exists(addr) ? exp_mem[addr] : 8'h00;
        end
        exp_q.push_back(it);
        outstanding++;
        req_valid = 1'b1;
        req_we = we;
        req_addr = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_check(input logic [7:0] exp_val, input string tag);
        wait (outstanding == 0);
        @(negedge clk);
        @(negedge clk);
        chk(!ad_oe && ad_o == exp_val, {"R10 keeper value ", tag}, ad_o, exp_val);
        chk(ad_keep == cfg_keep_en, {"R10 keeper flag ", tag}, ad_keep, cfg_keep_en);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ale && rd_n && wr_n && !ad_oe && !done, "R1 reset outputs",
            {ale, rd_n, wr_n, ad_oe, done}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 split sectors, opposite waits
        cfg_limit = 4'd8; cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd3;
        access(1, 16'h1234, 8'hA5);
        access(0, 16'h1234, 8'h00);
        access(1, 16'h9ABC, 8'h3C);
        access(0, 16'h9ABC, 8'h00);
        access(0, 16'h5555, 8'h00);
        cfg_ws_lo = 2'd1; cfg_ws_hi = 2'd2;
        access(1, 16'h7001, 8'h5A);
        access(0, 16'h7001, 8'h00);
        access(1, 16'h8002, 8'hC3);
        access(0, 16'h8002, 8'h00);
        // R7 threshold 0 sends all addresses upper
        cfg_limit = 4'd0; cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd3;
        access(0, 16'h0010, 8'h00);
        access(1, 16'h0010, 8'h11);
        // R7 threshold 15
        cfg_limit = 4'd15; cfg_ws_lo = 2'd2; cfg_ws_hi = 2'd1;
        access(1, 16'hE0FF, 8'h77);
        access(1, 16'hF000, 8'h88);
        access(0, 16'hE0FF, 8'h00);
        access(0, 16'hF000, 8'h00);

        // R10 keeper after write and after read
        cfg_keep_en = 1'b1;
        access(1, 16'h2200, 8'hE7);
        idle_check(8'hE7, "after write");
        cfg_keep_en = 1'b0;
        idle_check(8'hE7, "disabled");
        access(0, 16'h22F1, 8'h00);
        idle_check(8'hF1, "after read");
        cfg_keep_en = 1'b1;
        idle_check(8'hF1, "enabled");

        // R9 requests while busy are ignored
        cfg_limit = 4'd8; cfg_ws_lo = 2'd3; cfg_ws_hi = 2'd3;
        access(1, 16'h3300, 8'h42);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h4400; req_wdata = 8'h99;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait (outstanding == 0);
        repeat (4) @(negedge clk);
        chk(!ale && rd_n && wr_n, "R9 no extra access", ale, 0);
        access(0, 16'h4400, 8'h00);
        access(0, 16'h3300, 8'h00);

        wait (outstanding == 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all accesses completed", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule